// File: doc/BRIEF.md
# Virtually Tagged Cache with Process Identifiers

This block is a read cache that sits next to the processor. It is direct mapped and works only on virtual addresses. The set is picked by virtual bits 9..4. Each line stores virtual bits 31..10 and the 8-bit identifier of the process that filled it. Because the identifier is part of the match, a context switch only changes the identifier on the request, and lines owned by other processes stay resident. A lookup that finds a valid line with a matching tag and identifier answers without any address translation.

On a miss the block works through three steps in order. First it asks the translation port for the physical page of the virtual page, sending the process identifier with it. Then it asks memory for the whole 16-byte line at the physical address. Finally it installs the line and returns the requested 32-bit word. Only one request is in flight at a time. The request port reports not ready from acceptance until the response handshake.

The three flowing interfaces use valid/ready. A sender keeps valid and payload stable until ready is seen, and the transfer happens on a clock edge where both are high. The block applies this rule to its own translation and memory requests and to its CPU response. The translation and memory responses have no ready: the block takes them in the cycle they arrive, and they may only be sent for an outstanding request. A separate flush input clears every valid bit in one cycle.

Top module: `vt_cache`

## Requirements
- R1: After reset the block reports request ready, and no response, translation request or memory request is valid.
- R2: A request whose set holds a valid line with equal virtual tag (bits 31..10) and equal process identifier is a hit. Its response becomes valid in the second cycle after acceptance, and no translation request is made.
- R3: Any other request makes exactly one translation request, carrying virtual page bits 31..12 and the request's process identifier.
- R4: The memory request follows the translation response and carries the address {returned physical page, virtual bits 11..4, 4'b0}.
- R5: The response data is 32-bit word number vaddr[3:2] of the line, where word 0 is bits 31..0 of the 128-bit line. This holds both on a hit and on a refill.
- R6: A line filled under one process identifier never hits for a request with a different identifier, even at the same virtual address.
- R7: A one-cycle flush pulse invalidates all lines, so the next access to any address misses.
- R8: Request ready stays low from acceptance until the response handshake.
- R9: While the response is valid and not taken, it stays valid with stable data.
- R10: A fill replaces whatever line sat in its set. Two addresses with the same bits 9..4 and different bits 31..10 evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_vaddr | input | 32 | Virtual byte address |
| cpu_req_pid | input | 8 | Current process identifier |
| cpu_resp_valid | output | 1 | Read data valid |
| cpu_resp_ready | input | 1 | CPU takes the data |
| cpu_resp_data | output | 32 | Read word |
| xlt_req_valid | output | 1 | Translation request valid |
| xlt_req_ready | input | 1 | Translator accepts request |
| xlt_req_vpn | output | 20 | Virtual page number |
| xlt_req_pid | output | 8 | Process identifier for translation |
| xlt_resp_valid | input | 1 | Translation result valid |
| xlt_resp_ppn | input | 20 | Physical page number |
| mem_req_valid | output | 1 | Line fetch request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_paddr | output | 32 | Line-aligned physical address |
| mem_resp_valid | input | 1 | Line data valid |
| mem_resp_data | input | 128 | Line data, word 0 in bits 31..0 |

## Verification
A line whose stored identifier or valid bit is wrong appears at the ports in one of two ways. An access that should hit issues a translation request within one cycle of acceptance. An access that should miss returns data two cycles after acceptance with no translation, which is a false hit from another process or from before a flush. Corrupt data storage or a wrong word select shows up as a response word that differs from the expected function of the physical line address. A control state that skips a step shows up as a memory request without a prior translation response, or as a request port that becomes ready while a response is still pending.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_XREQ,
    ST_XWAIT,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } vc_state_e;
endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PID_W-1:0] wr_pid
);
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [PID_W-1:0] pid_q [LINES];

  // flush wins over a fill landing in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (flush) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      pid_q[wr_idx] <= wr_pid;
    end
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && (pid_q[lk_idx] == lk_pid);
endmodule

// File: rtl/vc_data_store.sv
module vc_data_store #(
  parameter int LINES  = 64,
  parameter int IDX_W  = 6,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] lane_out [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [WORD_W-1:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (wr_en) lane_q[wr_idx] <= wr_line[w*WORD_W +: WORD_W];
    end
    assign lane_out[w] = lane_q[rd_idx];
  end

  assign rd_data = lane_out[rd_word];
endmodule

// File: rtl/vc_miss_ctrl.sv
module vc_miss_ctrl
  import vc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic lk_hit,
  output logic accept,
  output logic hit_take,
  output logic xlt_req_valid,
  input  logic xlt_req_ready,
  input  logic xlt_resp_valid,
  output logic ppn_take,
  output logic mem_req_valid,
  input  logic mem_req_ready,
  input  logic mem_resp_valid,
  output logic fill,
  output logic resp_valid,
  input  logic resp_ready
);
  vc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid)      st_d = ST_LOOKUP;
      ST_LOOKUP:                     st_d = lk_hit ? ST_RESP : ST_XREQ;
      ST_XREQ:   if (xlt_req_ready)  st_d = ST_XWAIT;
      ST_XWAIT:  if (xlt_resp_valid) st_d = ST_MREQ;
      ST_MREQ:   if (mem_req_ready)  st_d = ST_MWAIT;
      ST_MWAIT:  if (mem_resp_valid) st_d = ST_RESP;
      ST_RESP:   if (resp_ready)     st_d = ST_IDLE;
      default:                       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign hit_take      = (st_q == ST_LOOKUP) && lk_hit;
  assign xlt_req_valid = (st_q == ST_XREQ);
  assign ppn_take      = (st_q == ST_XWAIT) && xlt_resp_valid;
  assign mem_req_valid = (st_q == ST_MREQ);
  assign fill          = (st_q == ST_MWAIT) && mem_resp_valid;
  assign resp_valid    = (st_q == ST_RESP);
endmodule

// File: rtl/vt_cache.sv
module vt_cache #(
  parameter int ADDR_W     = 32,
  parameter int PID_W      = 8,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int PAGE_BITS  = 12,
  localparam int WORD_W = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int VPN_W  = ADDR_W - PAGE_BITS,
  localparam int WORDS  = LINE_BYTES / 4,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_vaddr,
  input  logic [PID_W-1:0]  cpu_req_pid,
  output logic              cpu_resp_valid,
  input  logic              cpu_resp_ready,
  output logic [WORD_W-1:0] cpu_resp_data,
  output logic              xlt_req_valid,
  input  logic              xlt_req_ready,
  output logic [VPN_W-1:0]  xlt_req_vpn,
  output logic [PID_W-1:0]  xlt_req_pid,
  input  logic              xlt_resp_valid,
  input  logic [VPN_W-1:0]  xlt_resp_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_paddr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_data
);
  logic [ADDR_W-1:2] va_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  ppn_q;
  logic [WORD_W-1:0] data_q;

  logic accept, hit_take, ppn_take, fill, lk_hit;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  vtag;
  logic [WSEL_W-1:0] wsel;
  logic [WORD_W-1:0] hit_word, fill_word;

  assign idx  = va_q[OFF_W +: IDX_W];
  assign vtag = va_q[ADDR_W-1 -: TAG_W];
  assign wsel = va_q[2 +: WSEL_W];
  assign fill_word = mem_resp_data[wsel*WORD_W +: WORD_W];

  vc_miss_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (cpu_req_valid),
    .req_ready      (cpu_req_ready),
    .lk_hit         (lk_hit),
    .accept         (accept),
    .hit_take       (hit_take),
    .xlt_req_valid  (xlt_req_valid),
    .xlt_req_ready  (xlt_req_ready),
    .xlt_resp_valid (xlt_resp_valid),
    .ppn_take       (ppn_take),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .fill           (fill),
    .resp_valid     (cpu_resp_valid),
    .resp_ready     (cpu_resp_ready)
  );

  vc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PID_W(PID_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .lk_idx (idx),
    .lk_tag (vtag),
    .lk_pid (pid_q),
    .lk_hit (lk_hit),
    .wr_en  (fill),
    .wr_idx (idx),
    .wr_tag (vtag),
    .wr_pid (pid_q)
  );

  vc_data_store #(.LINES(LINES), .IDX_W(IDX_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
    .clk     (clk),
    .wr_en   (fill),
    .wr_idx  (idx),
    .wr_line (mem_resp_data),
    .rd_idx  (idx),
    .rd_word (wsel),
    .rd_data (hit_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      pid_q  <= '0;
      ppn_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept) begin
        va_q  <= cpu_req_vaddr[ADDR_W-1:2];
        pid_q <= cpu_req_pid;
      end
      if (ppn_take) ppn_q <= xlt_resp_ppn;
      if (hit_take)  data_q <= hit_word;
      else if (fill) data_q <= fill_word;
    end
  end

  assign cpu_resp_data = data_q;
  assign xlt_req_vpn   = va_q[ADDR_W-1 -: VPN_W];
  assign xlt_req_pid   = pid_q;
  assign mem_req_paddr = {ppn_q, va_q[PAGE_BITS-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/vt_cache_chk.sv
module vt_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_valid,
  input logic        cpu_req_ready,
  input logic        cpu_resp_valid,
  input logic        cpu_resp_ready,
  input logic [31:0] cpu_resp_data,
  input logic        xlt_req_valid,
  input logic        xlt_req_ready,
  input logic [19:0] xlt_req_vpn,
  input logic [7:0]  xlt_req_pid,
  input logic        xlt_resp_valid,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_paddr
);
  logic       xlt_seen_q;
  logic [1:0] xlt_hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlt_seen_q <= 1'b0;
      xlt_hs_q   <= '0;
    end else if (cpu_req_valid && cpu_req_ready) begin
      xlt_seen_q <= 1'b0;
      xlt_hs_q   <= '0;
    end else begin
      if (xlt_resp_valid) xlt_seen_q <= 1'b1;
      if (xlt_req_valid && xlt_req_ready && xlt_hs_q != 2'd3) xlt_hs_q <= xlt_hs_q + 2'd1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cpu_req_ready && !cpu_resp_valid && !xlt_req_valid && !mem_req_valid);

  a_r3_one_xlt_per_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (xlt_req_valid && xlt_req_ready) |-> (xlt_hs_q == 2'd0));

  a_r3_xlt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xlt_req_valid && !xlt_req_ready) |=> xlt_req_valid && $stable(xlt_req_vpn) && $stable(xlt_req_pid));

  a_r4_mem_after_xlt: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> xlt_seen_q);

  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_paddr));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid || xlt_req_valid || mem_req_valid) |-> !cpu_req_ready);

  a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_resp_valid && !cpu_resp_ready) |=> cpu_resp_valid && $stable(cpu_resp_data));
endmodule

bind vt_cache vt_cache_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_valid  (cpu_req_valid),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_resp_valid (cpu_resp_valid),
  .cpu_resp_ready (cpu_resp_ready),
  .cpu_resp_data  (cpu_resp_data),
  .xlt_req_valid  (xlt_req_valid),
  .xlt_req_ready  (xlt_req_ready),
  .xlt_req_vpn    (xlt_req_vpn),
  .xlt_req_pid    (xlt_req_pid),
  .xlt_resp_valid (xlt_resp_valid),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_paddr  (mem_req_paddr)
);

// File: tb/vt_cache_tb_top.sv
`timescale 1ns/1ps
module vt_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_ready;
  logic [31:0] cpu_req_vaddr = '0;
  logic [7:0]  cpu_req_pid = '0;
  logic cpu_resp_valid, cpu_resp_ready = 1'b0;
  logic [31:0] cpu_resp_data;
  logic xlt_req_valid, xlt_req_ready = 1'b0;
  logic [19:0] xlt_req_vpn;
  logic [7:0]  xlt_req_pid;
  logic xlt_resp_valid = 1'b0;
  logic [19:0] xlt_resp_ppn = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_paddr;
  logic mem_resp_valid = 1'b0;
  logic [127:0] mem_resp_data = '0;

  always #2.5 clk = ~clk;

  vt_cache dut_i (.*);

  int unsigned checks = 0, errors = 0, n_xlt = 0;
  bit done = 1'b0;
  logic [31:0] cur_va;
  logic [7:0]  cur_pid;
  bit m_v [64];
  logic [21:0] m_tag [64];
  logic [7:0]  m_pid [64];

  function automatic logic [19:0] xlate(input logic [19:0] vpn, input logic [7:0] pid);
    return vpn ^ {pid, 12'h000} ^ 20'h3_1000;
  endfunction

  function automatic logic [31:0] line_word(input logic [31:0] pa, input int w);
    return {pa[31:4], 2'(w), 2'b00} ^ 32'h5A0F_3C96;
  endfunction

  function automatic logic [31:0] exp_paddr(input logic [31:0] va, input logic [7:0] pid);
    return {xlate(va[31:12], pid), va[11:4], 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // translation responder
  int x_cnt = 0;
  logic [19:0] x_ppn;
  always @(negedge clk) if (rst_n) begin
    xlt_resp_valid = 1'b0;
    if (x_cnt > 0) begin
      x_cnt--;
      if (x_cnt == 0) begin xlt_resp_valid = 1'b1; xlt_resp_ppn = x_ppn; end
    end
    xlt_req_ready = ($urandom % 3) != 0;
    if (xlt_req_valid && xlt_req_ready) begin
      n_xlt++;
      chk(xlt_req_vpn == cur_va[31:12], "R3 vpn", 32'(xlt_req_vpn), 32'(cur_va[31:12]));
      chk(xlt_req_pid == cur_pid, "R3 pid", 32'(xlt_req_pid), 32'(cur_pid));
      x_ppn = xlate(xlt_req_vpn, xlt_req_pid);
      x_cnt = 1 + int'($urandom % 3);
    end
  end

  // memory responder
  int m_cnt = 0;
  logic [31:0] m_pa;
  always @(negedge clk) if (rst_n) begin
    mem_resp_valid = 1'b0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        mem_resp_valid = 1'b1;
        for (int w = 0; w < 4; w++) mem_resp_data[w*32 +: 32] = line_word(m_pa, w);
      end
    end
    mem_req_ready = ($urandom % 3) != 0;
    if (mem_req_valid && mem_req_ready) begin
      chk(mem_req_paddr == exp_paddr(cur_va, cur_pid), "R4 paddr", mem_req_paddr, exp_paddr(cur_va, cur_pid));
      m_pa = mem_req_paddr;
      m_cnt = 1 + int'($urandom % 4);
    end
  end

  task automatic access(input logic [31:0] va, input logic [7:0] pid);
    int idx, lat;
    bit hit, tag_eq, acc, seen, busy_ok;
    logic [31:0] exp, held;
    int unsigned x0;
    idx = int'(va[9:4]);
    tag_eq = m_v[idx] && m_tag[idx] == va[31:10];
    hit = tag_eq && m_pid[idx] == pid;
    exp = line_word(exp_paddr(va, pid), int'(va[3:2]));
    cur_va = va; cur_pid = pid; x0 = n_xlt;
    cpu_req_vaddr = va; cpu_req_pid = pid; cpu_req_valid = 1'b1;
    do begin acc = cpu_req_ready; @(negedge clk); end while (!acc);
    cpu_req_valid = 1'b0;
    lat = 1; seen = 0; busy_ok = 1; held = '0;
    forever begin
      if (!cpu_resp_valid && cpu_req_ready) busy_ok = 0;
      if (cpu_resp_valid) begin
        if (seen) chk(cpu_resp_data == held, "R9 hold", cpu_resp_data, held);
        else if (hit) chk(lat == 2, "R2 latency", 32'(lat), 32'd2);
        seen = 1; held = cpu_resp_data;
        chk(!cpu_req_ready, "R8 ready low", 32'(cpu_req_ready), 32'd0);
      end
      cpu_resp_ready = ($urandom % 3) != 0;
      if (cpu_resp_valid && cpu_resp_ready) break;
      @(negedge clk);
      lat++;
    end
    chk(cpu_resp_data == exp, "R5 data", cpu_resp_data, exp);
    chk(busy_ok, "R8 busy", 32'(busy_ok), 32'd1);
    if (hit)         chk(n_xlt == x0, "R2 no xlt", n_xlt, x0);
    else if (tag_eq) chk(n_xlt == x0 + 1, "R6 pid miss", n_xlt, x0 + 1);
    else             chk(n_xlt == x0 + 1, "R3 one xlt", n_xlt, x0 + 1);
    @(negedge clk);
    cpu_resp_ready = 1'b0;
    if (!hit) begin m_v[idx] = 1; m_tag[idx] = va[31:10]; m_pid[idx] = pid; end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready && !cpu_resp_valid && !xlt_req_valid && !mem_req_valid, "R1 reset",
        {28'h0, cpu_req_ready, cpu_resp_valid, xlt_req_valid, mem_req_valid}, 32'h8);
    // directed: miss, hit, other process, eviction, flush
    access(32'h0001_2344, 8'h05);
    access(32'h0001_2348, 8'h05);          // R2 hit, word 2
    access(32'h0001_234C, 8'h06);          // R6 other pid misses
    access(32'h0001_2340, 8'h06);          // hit for pid 6 now
    access(32'h0001_2744, 8'h06);          // R10 same set, new tag evicts
    access(32'h0001_2340, 8'h06);          // R10 evicted line misses again
    access(32'h0001_2350, 8'h06);          // neighbour set
    do_flush();                            // R7
    access(32'h0001_2350, 8'h06);          // R7 misses after flush
    access(32'h0001_2350, 8'h06);
    for (int k = 0; k < 300; k++) begin
      logic [31:0] va;
      if ($urandom % 40 == 0) do_flush();
      va = 32'h0004_0000 | (32'($urandom % 4) << 10) | (32'($urandom % 8) << 4) | (32'($urandom % 4) << 2);
      access(va, 8'h10 + 8'($urandom % 3));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule